// File: doc/BRIEF.md
# Programmable Reference Divider with Dual Tap Selection

This block slows a reference clock down to the comparison rates of two phase detectors. A programmable stage divides the reference by a 10-bit ratio and emits a one-cycle terminal-count strobe. A 3-bit binary counter advances on each strobe. Together they give four aligned taps: the strobe itself, and the strobe thinned to every second, fourth and eighth occurrence. The taps are aligned because every coarser tap fires only on a cycle on which all finer taps also fire.

Each output has its own 2-bit select code that picks one tap. The main output and the auxiliary output decode that code in opposite directions. With equal codes the two outputs therefore sit on different taps, and their comparison pulses are spread apart in time. Each output is a registered pulse one reference cycle wide.

The divider chain runs while either loop's enable is high. When both enables are low, the chain returns to its starting phase. The outputs therefore line up predictably when a loop is powered up.

Top module: `refdiv_tap_sel`

## Requirements
- R1: While `rst` is high, both outputs are low. After `rst` falls, the divider chain starts from count zero.
- R2: With a ratio N, the undivided tap fires every N reference cycles. Its first pulse appears N cycles after the chain starts running.
- R3: The main select decodes as follows: 00 takes the undivided tap, 01 takes ÷2, 10 takes ÷4 and 11 takes ÷8. The main pulse period is N, 2N, 4N or 8N.
- R4: The auxiliary select decodes in reverse: 11 takes the undivided tap, 10 takes ÷2, 01 takes ÷4 and 00 takes ÷8.
- R5: Every output pulse lasts exactly one reference cycle.
- R6: A ratio below 4 behaves as a ratio of 4.
- R7: A ratio change lets the running division finish with the old ratio. The new ratio governs every division after the next terminal count.
- R8: The chain runs while `main_en` or `aux_en` is high. An output whose own enable is low stays low, even while the chain runs for the other output.
- R9: When both enables are low, the chain returns to its starting phase and both outputs stay low. A later enable restarts it, with the first pulse of each tap due exactly as in R2 and R3.
- R10: Taps are nested. Whenever a coarser tap fires, every finer tap fires in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| ratio | input | 10 | Programmable division ratio (4 to 1023; smaller values are clamped to 4) |
| main_sel | input | 2 | Tap select for the main output |
| aux_sel | input | 2 | Tap select for the auxiliary output (reversed decode) |
| main_en | input | 1 | Main loop enable |
| aux_en | input | 1 | Auxiliary loop enable |
| main_pulse | output | 1 | Main comparison pulse |
| aux_pulse | output | 1 | Auxiliary comparison pulse |

## Verification
Suppose the chain starts running at some clock edge. Tap k then delivers its first pulse N·2^k edges later, and the output register adds no extra cycle beyond that edge. Pulses then repeat every N·2^k edges. A ratio written in mid-period changes only the period after the one that is running. The bench counts rising edges from the cycle in which an enable is driven, and it samples on the falling edge. Each first-pulse index and each pulse-to-pulse interval is therefore compared against N·2^k with no slack. A disabled output is watched over a window that covers two full periods of the slowest enabled tap.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  localparam int TAP_COUNT = 4;
  localparam int SEL_W     = $clog2(TAP_COUNT);

  typedef logic [SEL_W-1:0] tap_sel_t;

  // Map a select code onto a tap index; the reversed decode mirrors it.
  function automatic tap_sel_t tap_index(input tap_sel_t code, input bit reverse);
    return reverse ? tap_sel_t'(TAP_COUNT - 1 - int'(code)) : code;
  endfunction
endpackage

// File: rtl/refdiv_prog.sv
module refdiv_prog #(
  parameter int RATIO_W   = 10,
  parameter int MIN_RATIO = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic [RATIO_W-1:0] ratio,
  output logic               tc
);
  localparam logic [RATIO_W-1:0] FLOOR = RATIO_W'(MIN_RATIO);

  logic [RATIO_W-1:0] pos;
  logic [RATIO_W-1:0] active;
  logic [RATIO_W-1:0] clamped;

  assign clamped = (ratio < FLOOR) ? FLOOR : ratio;
  assign tc      = run && (pos == active - RATIO_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pos    <= '0;
      active <= clamped;
    end else if (tc) begin
      pos    <= '0;
      active <= clamped;
    end else begin
      pos    <= pos + RATIO_W'(1);
    end
  end

  // R6
  ratio_floor_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> active >= FLOOR);

  // R2
  pos_range_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> pos < active);

  // R7
  hold_ratio_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !tc) |=> $stable(active));
endmodule

// File: rtl/refdiv_octave.sv
module refdiv_octave
  import refdiv_pkg::*;
#(
  parameter int TAPS = TAP_COUNT
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            tc,
  output logic [TAPS-1:0] tap_hit
);
  localparam int CW = TAPS - 1;

  logic [CW-1:0] oct;

  always_ff @(posedge clk) begin
    if (rst || !run) oct <= '0;
    else if (tc)     oct <= oct + CW'(1);
  end

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    if (k == 0) begin : g_base
      assign tap_hit[k] = tc;
    end else begin : g_div
      assign tap_hit[k] = tc && (&oct[k-1:0]);
    end
  end

  // R10
  octave_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !tc) |=> $stable(oct));

  // R9
  octave_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> oct == '0);
endmodule

// File: rtl/refdiv_pick.sv
module refdiv_pick
  import refdiv_pkg::*;
#(
  parameter int TAPS    = TAP_COUNT,
  parameter bit REVERSE = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            enable,
  input  tap_sel_t        sel,
  input  logic [TAPS-1:0] tap_hit,
  output logic            pulse
);
  tap_sel_t idx;

  assign idx = tap_index(sel, REVERSE);

  always_ff @(posedge clk) begin
    if (rst) pulse <= 1'b0;
    else     pulse <= enable && tap_hit[idx];
  end

  // R5
  one_wide_chk: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);

  // R8
  gated_off_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !pulse);
endmodule

// File: rtl/refdiv_tap_sel.sv
module refdiv_tap_sel
  import refdiv_pkg::*;
#(
  parameter int RATIO_W   = 10,
  parameter int MIN_RATIO = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RATIO_W-1:0] ratio,
  input  logic [1:0]         main_sel,
  input  logic [1:0]         aux_sel,
  input  logic               main_en,
  input  logic               aux_en,
  output logic               main_pulse,
  output logic               aux_pulse
);
  logic                 run;
  logic                 tc;
  logic [TAP_COUNT-1:0] tap_hit;

  assign run = main_en | aux_en;

  refdiv_prog #(.RATIO_W(RATIO_W), .MIN_RATIO(MIN_RATIO)) prog_i (
    .clk(clk), .rst(rst), .run(run), .ratio(ratio), .tc(tc)
  );

  refdiv_octave #(.TAPS(TAP_COUNT)) octave_i (
    .clk(clk), .rst(rst), .run(run), .tc(tc), .tap_hit(tap_hit)
  );

  refdiv_pick #(.TAPS(TAP_COUNT), .REVERSE(1'b0)) main_pick_i (
    .clk(clk), .rst(rst), .enable(main_en), .sel(tap_sel_t'(main_sel)),
    .tap_hit(tap_hit), .pulse(main_pulse)
  );

  refdiv_pick #(.TAPS(TAP_COUNT), .REVERSE(1'b1)) aux_pick_i (
    .clk(clk), .rst(rst), .enable(aux_en), .sel(tap_sel_t'(aux_sel)),
    .tap_hit(tap_hit), .pulse(aux_pulse)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> !main_pulse && !aux_pulse);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> !main_pulse && !aux_pulse);
endmodule

// File: tb/refdiv_tap_sel_tb_top.sv
`timescale 1ns/1ps
module refdiv_tap_sel_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic [9:0] ratio;
  logic [1:0] main_sel, aux_sel;
  logic       main_en, aux_en;
  logic       main_pulse, aux_pulse;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  refdiv_tap_sel dut_i (
    .clk(clk), .rst(rst), .ratio(ratio), .main_sel(main_sel), .aux_sel(aux_sel),
    .main_en(main_en), .aux_en(aux_en), .main_pulse(main_pulse), .aux_pulse(aux_pulse)
  );

  // {ratio[15:6], main_sel[5:4], aux_sel[3:2], main_en[1], aux_en[0]}
  localparam logic [15:0] VEC [8] = '{
    {10'd5,    2'd0, 2'd0, 1'b1, 1'b1},
    {10'd4,    2'd1, 2'd1, 1'b1, 1'b1},
    {10'd7,    2'd2, 2'd2, 1'b1, 1'b1},
    {10'd3,    2'd3, 2'd3, 1'b1, 1'b1},
    {10'd0,    2'd0, 2'd3, 1'b1, 1'b1},
    {10'd1023, 2'd0, 2'd2, 1'b1, 1'b1},
    {10'd10,   2'd3, 2'd0, 1'b1, 1'b0},
    {10'd6,    2'd1, 2'd1, 1'b0, 1'b1}
  };

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic go_idle();
    @(negedge clk);
    main_en = 1'b0; aux_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // Runs one setting from an idle chain; checks first pulse, interval, width, nesting.
  task automatic run_vec(input logic [9:0] r, input logic [1:0] ms, input logic [1:0] as_,
                         input logic pm, input logic pa);
    int n, mp, ap, lim, c, m1, m2, a1, a2, wide;
    bit pm_prev, pa_prev;
    n  = (r < 4) ? 4 : int'(r);
    mp = n << ms;
    ap = n << (3 - as_);
    lim = 2 * (((pm && mp > ap) || !pa) ? mp : ap) + 4;
    go_idle();
    ratio = r; main_sel = ms; aux_sel = as_;
    @(negedge clk);
    main_en = pm; aux_en = pa;
    c = 0; m1 = 0; m2 = 0; a1 = 0; a2 = 0; wide = 0;
    pm_prev = 0; pa_prev = 0;
    while (c < lim) begin
      @(negedge clk);
      c++;
      if (main_pulse) begin
        if (m1 == 0) m1 = c; else if (m2 == 0) m2 = c;
      end
      if (aux_pulse) begin
        if (a1 == 0) a1 = c; else if (a2 == 0) a2 = c;
        if (pm && (int'(ms) <= 3 - int'(as_)))
          chk("R10 finer main tap fires with aux", int'(main_pulse), 1);
      end
      if ((main_pulse && pm_prev) || (aux_pulse && pa_prev)) wide++;
      pm_prev = main_pulse; pa_prev = aux_pulse;
    end
    chk("R5 pulse width", wide, 0);
    if (pm) begin
      chk("R3 R6 main first pulse", m1, mp);
      chk("R2 R3 main interval", m2 - m1, mp);
    end else begin
      chk("R8 main held off", m1, 0);
    end
    if (pa) begin
      chk("R4 R6 aux first pulse", a1, ap);
      chk("R4 aux interval", a2 - a1, ap);
    end else begin
      chk("R8 aux held off", a1, 0);
    end
  endtask

  initial begin
    int c, p1, p2;
    rst = 1'b1; ratio = 10'd4; main_sel = 2'd0; aux_sel = 2'd3;
    main_en = 1'b1; aux_en = 1'b1;
    repeat (8) begin
      @(negedge clk);
      chk("R1 outputs low in reset", int'(main_pulse | aux_pulse), 0);
    end
    // R1: chain starts at zero when reset drops, first tap0 pulse after 4 edges
    rst = 1'b0;
    c = 0; p1 = 0;
    while (c < 6) begin
      @(negedge clk); c++;
      if (main_pulse && p1 == 0) p1 = c;
    end
    chk("R1 first pulse after reset", p1, 4);

    foreach (VEC[i])
      run_vec(VEC[i][15:6], VEC[i][5:4], VEC[i][3:2], VEC[i][1], VEC[i][0]);

    // R7: ratio change mid period, old ratio finishes then new one applies
    go_idle();
    ratio = 10'd5; main_sel = 2'd0; aux_sel = 2'd0;
    @(negedge clk);
    main_en = 1'b1;
    c = 0; p1 = 0; p2 = 0;
    while (c < 20) begin
      @(negedge clk); c++;
      if (c == 2) ratio = 10'd9;
      if (main_pulse) begin
        if (p1 == 0) p1 = c; else if (p2 == 0) p2 = c;
      end
    end
    chk("R7 old ratio completes", p1, 5);
    chk("R7 new ratio next", p2, 14);

    // R9: stop mid octave, restart realigns aux ÷8 tap
    go_idle();
    ratio = 10'd4; main_sel = 2'd0; aux_sel = 2'd0;
    @(negedge clk);
    main_en = 1'b1; aux_en = 1'b1;
    repeat (10) @(negedge clk);
    main_en = 1'b0; aux_en = 1'b0;
    c = 0; p1 = 0;
    repeat (3) begin
      @(negedge clk);
      if (main_pulse | aux_pulse) p1++;
    end
    chk("R9 quiet while both off", p1, 0);
    main_en = 1'b1; aux_en = 1'b1;
    c = 0; p1 = 0; p2 = 0;
    while (c < 36) begin
      @(negedge clk); c++;
      if (main_pulse && p1 == 0) p1 = c;
      if (aux_pulse && p2 == 0) p2 = c;
    end
    chk("R9 main restart phase", p1, 4);
    chk("R9 aux restart phase", p2, 32);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule